// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block drives one pulse-width-modulated output. Its time base is an 8-bit timer with two fine bits below it, so the compare runs at 10-bit resolution. Each fine step lasts one, four or sixteen input clocks, set by a prescale field. Software sets the period through an 8-bit period register. It sets the duty through an 8-bit high byte and a 2-bit low field. Together these form a 10-bit master duty.

The output runs on a set/reset latch. When the timer passes its period value, a new period starts: the timer and prescaler restart, the master duty is copied into a slave register, and the latch is set. The latch is cleared when the time base reaches the slave duty. Software can therefore rewrite the duty at any moment, and the current period is never disturbed.

A postscaler counts period boundaries and raises a one-cycle interrupt flag every N of them. It has no effect on the waveform. Writing zero to the control register disables the block and drives the output low.

Top module: `pwmGen`

## Requirements
- R1: Write port: when `wrEn` is high, `wrData` is stored at `wrAddr`. Address 0 is the period register (reset value 0xFF). Address 1 is the duty high byte (reset 0). Address 2 is the control register (reset 0): bits [1:0] are the duty low bits, bits [3:2] select the prescale, bit [4] is the enable. Address 3 holds the postscale select in bits [3:0] (reset 0).
- R2: The prescale select encodes 0 as 1, 1 as 4, and 2 or 3 as 16. One PWM period lasts (period + 1) × 4 × prescale input clocks.
- R3: At the last input clock of the timer step in which the timer is at or above the period value, the timer and prescaler both return to zero.
- R4: At each period boundary with a nonzero master duty, the output goes high in the first cycle of the new period.
- R5: When the master duty is zero at a period boundary, the output stays low for the whole next period.
- R6: The master duty {high byte, low bits} is copied into the slave only at a period boundary. A duty write made during a period changes only the periods that follow it.
- R7: Within a period the output is high for exactly duty × prescale input clocks, starting at the boundary.
- R8: When the duty is greater than or equal to (period + 1) × 4, the output stays high for the whole period.
- R9: The postscaler raises `intFlag` for one cycle, in the first cycle of a period, once every (postscale select + 1) periods. The PWM period does not change with the postscale setting.
- R10: While the enable bit is clear, the output is low from the next cycle onward. The timer, prescaler, slave duty and postscaler are held at zero and `intFlag` stays low. As a result, the first period after the block is enabled is low.
- R11: After reset, `pwmOut` and `intFlag` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | 8 | Register write data |
| pwmOut | output | 1 | PWM output latch |
| intFlag | output | 1 | One-cycle postscaled period interrupt |

## Verification
Latch set and latch reset can land in the same cycle. This happens when the duty equals exactly (period + 1) × 4: the reset compare then matches on the boundary clock itself. The bench provokes this case with period 3 and duty 16. It passes only if the output stays high for all 16 cycles, with no one-cycle dip at the boundary. The bench also writes a new duty in the middle of a period, so a master-register write is in flight while the slave copy governs the output, and checks that only the following period changes.

// File: rtl/pwmPkg.sv
package pwmPkg;
  localparam int PRE_SH_W = 3;

  typedef struct packed {
    logic clr;
    logic restart;
    logic loadSlave;
  } pwmStrobe_t;

  function automatic logic [PRE_SH_W-1:0] preShiftOf(input logic [1:0] sel);
    case (sel)
      2'b00:   preShiftOf = 3'd0;
      2'b01:   preShiftOf = 3'd2;
      default: preShiftOf = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pwmDatapath.sv
module pwmDatapath
  import pwmPkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pwmStrobe_t               strobe,
  input  logic [TMR_W-1:0]         periodReg,
  input  logic [TMR_W+FINE_W-1:0]  masterDuty,
  input  logic [PRE_SH_W-1:0]      preShift,
  output logic                     boundaryHit,
  output logic                     resetHit
);
  localparam int DUTY_W = TMR_W + FINE_W;
  localparam int DIV_W  = FINE_W + 4;
  localparam logic [DIV_W:0] ONE_W = (DIV_W+1)'(1);

  logic [DIV_W-1:0]  divCnt;
  logic [TMR_W-1:0]  tmr;
  logic [DUTY_W-1:0] slaveDuty;
  logic [DIV_W:0]    stepSpan, fineSpan;
  logic [DIV_W-1:0]  divMax, fineMask;
  logic [FINE_W-1:0] fine;
  logic [DUTY_W-1:0] timeBase;
  logic              divLast, fineTick;

  always_comb begin
    stepSpan = ONE_W << (FINE_W + int'(preShift));
    fineSpan = ONE_W << preShift;
    divMax   = DIV_W'(stepSpan - ONE_W);
    fineMask = DIV_W'(fineSpan - ONE_W);
    divLast  = (divCnt >= divMax);
    fineTick = ((divCnt & fineMask) == fineMask);
    fine     = FINE_W'(divCnt >> preShift);
    timeBase = {tmr, fine};
    boundaryHit = divLast && (tmr >= periodReg);
    resetHit    = fineTick && ((timeBase + DUTY_W'(1)) == slaveDuty);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      tmr       <= '0;
      slaveDuty <= '0;
    end else if (strobe.clr) begin
      divCnt    <= '0;
      tmr       <= '0;
      slaveDuty <= '0;
    end else begin
      if (strobe.restart) begin
        divCnt <= '0;
        tmr    <= '0;
      end else if (divLast) begin
        divCnt <= '0;
        tmr    <= tmr + TMR_W'(1);
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
      if (strobe.loadSlave) slaveDuty <= masterDuty;
    end
  end

  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (tmr == '0 && divCnt == '0)); // R3
  AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clr && !strobe.loadSlave) |=> $stable(slaveDuty)); // R6
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (slaveDuty == '0 && tmr == '0)); // R10
endmodule

// File: rtl/pwmControl.sv
module pwmControl
  import pwmPkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2,
  parameter int POST_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [1:0]               wrAddr,
  input  logic [TMR_W-1:0]         wrData,
  input  logic                     boundaryHit,
  input  logic                     resetHit,
  output pwmStrobe_t               strobe,
  output logic [TMR_W-1:0]         periodReg,
  output logic [TMR_W+FINE_W-1:0]  masterDuty,
  output logic [PRE_SH_W-1:0]      preShift,
  output logic                     pwmOut,
  output logic                     intFlag
);
  localparam int CTRL_W = FINE_W + 3;
  localparam int EN_BIT = FINE_W + 2;

  logic [TMR_W-1:0]  dutyHi;
  logic [CTRL_W-1:0] ctrlReg;
  logic [POST_W-1:0] postSel, postCnt;
  logic              runEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '1;
      dutyHi    <= '0;
      ctrlReg   <= '0;
      postSel   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        2'd0: periodReg <= wrData;
        2'd1: dutyHi    <= wrData;
        2'd2: ctrlReg   <= wrData[CTRL_W-1:0];
        default: postSel <= wrData[POST_W-1:0];
      endcase
    end
  end

  always_comb begin
    runEn            = ctrlReg[EN_BIT];
    masterDuty       = {dutyHi, ctrlReg[FINE_W-1:0]};
    preShift         = preShiftOf(ctrlReg[FINE_W+1:FINE_W]);
    strobe.clr       = !runEn;
    strobe.restart   = runEn && boundaryHit;
    strobe.loadSlave = runEn && boundaryHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmOut <= 1'b0;
    end else if (!runEn) begin
      pwmOut <= 1'b0;
    end else if (boundaryHit) begin
      pwmOut <= (masterDuty != '0);
    end else if (resetHit) begin
      pwmOut <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postCnt <= '0;
      intFlag <= 1'b0;
    end else if (!runEn) begin
      postCnt <= '0;
      intFlag <= 1'b0;
    end else begin
      intFlag <= 1'b0;
      if (boundaryHit) begin
        if (postCnt >= postSel) begin
          postCnt <= '0;
          intFlag <= 1'b1;
        end else begin
          postCnt <= postCnt + POST_W'(1);
        end
      end
    end
  end

  AST_SET_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && boundaryHit && masterDuty != '0) |=> pwmOut); // R4
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && boundaryHit && masterDuty == '0) |=> !pwmOut); // R5
  AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!pwmOut && !intFlag)); // R10
  AST_INT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    intFlag |=> !intFlag); // R9
endmodule

// File: rtl/pwmGen.sv
module pwmGen
  import pwmPkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2,
  parameter int POST_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [TMR_W-1:0] wrData,
  output logic             pwmOut,
  output logic             intFlag
);
  localparam int DUTY_W = TMR_W + FINE_W;

  pwmStrobe_t          strobe;
  logic [TMR_W-1:0]    periodReg;
  logic [DUTY_W-1:0]   masterDuty;
  logic [PRE_SH_W-1:0] preShift;
  logic                boundaryHit, resetHit;

  pwmControl #(.TMR_W(TMR_W), .FINE_W(FINE_W), .POST_W(POST_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .boundaryHit(boundaryHit), .resetHit(resetHit), .strobe(strobe),
    .periodReg(periodReg), .masterDuty(masterDuty), .preShift(preShift),
    .pwmOut(pwmOut), .intFlag(intFlag)
  );

  pwmDatapath #(.TMR_W(TMR_W), .FINE_W(FINE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .periodReg(periodReg),
    .masterDuty(masterDuty), .preShift(preShift),
    .boundaryHit(boundaryHit), .resetHit(resetHit)
  );
endmodule

// File: tb/pwmGen_tb_top.sv
module pwmGen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pwmOut, intFlag;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  pwmGen dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .intFlag(intFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<%0d cycles", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [7:0] ctrlVal(input bit en, input logic [1:0] pre, input logic [1:0] lo);
    return {3'b000, en, pre, lo};
  endfunction

  task automatic waitInt();
    @(negedge clk);
    while (!intFlag) @(negedge clk);
  endtask

  // Starts at a negedge where intFlag is high; counts to the next intFlag.
  task automatic measure(output int len, output int hi, output int rises,
                         input bit doWr, input logic [1:0] a, input logic [7:0] d);
    bit prev = 1'b0;
    len = 0; hi = 0; rises = 0;
    do begin
      if (pwmOut) hi++;
      if (pwmOut && !prev) rises++;
      prev = pwmOut;
      len++;
      if (doWr && len == 3) begin wrEn = 1'b1; wrAddr = a; wrData = d; end
      if (doWr && len == 4) wrEn = 1'b0;
      @(negedge clk);
    end while (!intFlag);
  endtask

  task automatic setup(input logic [7:0] per, input logic [7:0] hiB,
                       input logic [1:0] pre, input logic [1:0] lo);
    wr(2'd0, per);
    wr(2'd1, hiB);
    wr(2'd2, ctrlVal(1'b1, pre, lo));
    waitInt();
    waitInt();
  endtask

  task automatic testReset();
    @(negedge clk);
    check(pwmOut == 1'b0, "R11 pwmOut after reset", int'(pwmOut), 0);
    check(intFlag == 1'b0, "R11 intFlag after reset", int'(intFlag), 0);
  endtask

  task automatic testBasic();
    int len, hi, r;
    setup(8'd3, 8'd1, 2'b00, 2'b10);
    check(pwmOut == 1'b1, "R4 output high at period start", int'(pwmOut), 1);
    measure(len, hi, r, 1'b0, 2'd0, 8'd0);
    check(len == 16, "R2 R3 period length pre1", len, 16);
    check(hi == 6, "R1 R7 high time duty 6", hi, 6);
  endtask

  task automatic testZero();
    int len, hi, r;
    setup(8'd3, 8'd0, 2'b00, 2'b00);
    measure(len, hi, r, 1'b0, 2'd0, 8'd0);
    check(hi == 0, "R5 zero duty stays low", hi, 0);
    check(len == 16, "R5 period unchanged at zero duty", len, 16);
  endtask

  task automatic testFull();
    int len, hi, r;
    setup(8'd3, 8'd4, 2'b00, 2'b00);
    measure(len, hi, r, 1'b0, 2'd0, 8'd0);
    check(hi == 16, "R8 duty equal to period high whole period", hi, 16);
    setup(8'd3, 8'd5, 2'b00, 2'b01);
    measure(len, hi, r, 1'b0, 2'd0, 8'd0);
    check(hi == 16, "R8 duty above period high whole period", hi, 16);
  endtask

  task automatic testPrescale();
    int len, hi, r;
    setup(8'd2, 8'd1, 2'b01, 2'b01);
    measure(len, hi, r, 1'b0, 2'd0, 8'd0);
    check(len == 48, "R2 period length pre4", len, 48);
    check(hi == 20, "R7 high time duty 5 pre4", hi, 20);
    setup(8'd1, 8'd0, 2'b10, 2'b11);
    measure(len, hi, r, 1'b0, 2'd0, 8'd0);
    check(len == 128, "R2 period length pre16", len, 128);
    check(hi == 48, "R7 high time duty 3 pre16", hi, 48);
    setup(8'd3, 8'd0, 2'b01, 2'b01);
    measure(len, hi, r, 1'b0, 2'd0, 8'd0);
    check(hi == 4, "R7 single fine step pre4", hi, 4);
  endtask

  task automatic testBuffer();
    int len, hi, r;
    setup(8'd3, 8'd1, 2'b00, 2'b10);
    measure(len, hi, r, 1'b1, 2'd1, 8'd3);
    check(hi == 6, "R6 mid-period write not applied yet", hi, 6);
    measure(len, hi, r, 1'b0, 2'd0, 8'd0);
    check(hi == 14, "R6 new duty applied next period", hi, 14);
  endtask

  task automatic testPost();
    int len, hi, r;
    setup(8'd3, 8'd1, 2'b00, 2'b10);
    wr(2'd3, 8'd2);
    waitInt();
    waitInt();
    measure(len, hi, r, 1'b0, 2'd0, 8'd0);
    check(len == 48, "R9 intFlag every 3 periods", len, 48);
    check(r == 3, "R9 PWM period unchanged by postscaler", r, 3);
    check(hi == 18, "R9 high time over 3 periods", hi, 18);
    wr(2'd3, 8'd0);
  endtask

  task automatic testClear();
    int lowBad = 0, intSeen = 0, pre = 0;
    setup(8'd3, 8'd1, 2'b00, 2'b10);
    wr(2'd2, 8'd0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwmOut) lowBad++;
      if (intFlag) intSeen++;
    end
    check(lowBad == 0, "R10 output low while disabled", lowBad, 0);
    check(intSeen == 0, "R10 no intFlag while disabled", intSeen, 0);
    wr(2'd2, ctrlVal(1'b1, 2'b00, 2'b10));
    lowBad = 0;
    while (!intFlag) begin
      if (pwmOut) lowBad++;
      pre++;
      @(negedge clk);
    end
    check(lowBad == 0, "R10 first period after enable low", lowBad, 0);
    check(pwmOut == 1'b1, "R4 output high after first boundary", int'(pwmOut), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testZero();
    testFull();
    testPrescale();
    testBuffer();
    testPost();
    testClear();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule